// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM level into two gate-enable outputs, one for the high-side switch and one for the low-side switch of a synchronous buck stage. The two outputs never overlap. It runs on a system clock. The analog side of the stage reaches it only as digital flags: the switch node is below about 1 V, the switch node is high, and the low-side gate has decayed below one sixth of the supply. An active-low shutdown input parks both gates low.

When the high side is released, the block lets the low side on only once the switch node has been seen high and has then dropped below threshold. If the node never rose, a fixed dead-time is used instead. A hard limit turns the low side on if the node stays high, which happens with negative inductor current. When the low side is released, the block waits for the low-side gate-decay flag and then adds a short guard delay before the high side turns on.

All delays are given in picoseconds and rounded up to whole clock cycles. With a 20 ns clock, the defaults give 8 cycles (150 ns fixed), 10 cycles (190 ns limit) and 2 cycles (30 ns guard). Every input passes through a two-flop synchronizer. Each delay is counted from the synchronized view of its trigger.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both `gate_hi` and `gate_lo` are 0.
- R2: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R3: `shut_n` = 0 forces both outputs to 0 on the third rising clock edge after the change. They stay 0 for as long as it is held low, whatever `pwm_in` does.
- R4: With `shut_n` = 1 and the sequence settled, `pwm_in` = 1 gives `gate_hi` = 1, `gate_lo` = 0, and `pwm_in` = 0 gives `gate_hi` = 0, `gate_lo` = 1.
- R5: A rise of `pwm_in` clears `gate_lo` on the third rising edge after the change, and `gate_hi` is still 0 in that cycle.
- R6: After a rise of `pwm_in`, `gate_hi` stays 0 while `lsg_low` = 0. Once `lsg_low` goes to 1, `gate_hi` sets on rising edge 3 + GUARD (GUARD = 2 by default) after that change. `gate_lo` is 0 for at least two cycles before `gate_hi` rises.
- R7: A fall of `pwm_in` clears `gate_hi` on the third edge after the change. If `sw_above` = 1 was seen during the wait, `gate_lo` sets on the third edge after `sw_below` goes to 1.
- R8: If `sw_above` is never seen after `gate_hi` clears, `gate_lo` sets exactly FIXED (8 by default) cycles after `gate_hi` clears, even if `sw_below` = 1 all along.
- R9: If `sw_above` was seen but `sw_below` never arrives, `gate_lo` sets exactly LIMIT (10 by default) cycles after `gate_hi` clears. Both outputs are never low together for more than LIMIT cycles on this path.
- R10: If `pwm_in` reverses while a turn-on is pending, the pending output never asserts. The opposite sequence starts from the both-low state and completes with its normal delays.
- R11: When `shut_n` returns to 1, the block follows the normal sequence for the current `pwm_in` level. With `pwm_in` = 1 and `lsg_low` = 1, `gate_hi` sets on edge 4 + GUARD after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM level: 1 selects the high side, 0 selects the low side |
| shut_n | input | 1 | Active-low shutdown: 0 forces both gates low |
| sw_below | input | 1 | Switch node is below about 1 V |
| sw_above | input | 1 | Switch node is high |
| lsg_low | input | 1 | Low-side gate has decayed below one sixth of the supply |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
Any input change reaches the outputs on the third rising edge: two synchronizer flops, then the sequencer register. The fixed and limit delays are counted from the edge that clears `gate_hi`. The guard delay adds GUARD edges after the synchronized gate-decay flag. The bench drives inputs on falling edges and samples at a falling edge. For every timed result it checks the cycle just before the output is due, where the old value must still be present, and the cycle in which it is due. An early or late transition by even one cycle is therefore reported.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_HI_WAIT = 3'd1,
      PH_HI_HOLD = 3'd2,
      PH_HI_ON   = 3'd3,
      PH_LO_WAIT = 3'd4,
      PH_LO_ON   = 3'd5
   } phase_e;

   typedef struct packed {
      logic pwm;
      logic en;
      logic sw_lo;
      logic sw_hi;
      logic lg_off;
   } sense_t;

   function automatic int unsigned to_cycles(input int unsigned dur_ps,
                                             input int unsigned per_ps);
      return (dur_ps + per_ps - 1) / per_ps;
   endfunction

endpackage

// File: rtl/dtg_sync.sv
`timescale 1ns/1ps
module dtg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/dtg_timer.sv
`timescale 1ns/1ps
module dtg_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            count <= '0;
      else if (clear)        count <= '0;
      else if (count != TOP) count <= count + 1'b1;
   end
endmodule

// File: rtl/dtg_seq.sv
`timescale 1ns/1ps
module dtg_seq
   import dtg_pkg::*;
#(
   parameter int FIX_CYC = 8,
   parameter int TMO_CYC = 10,
   parameter int HSD_CYC = 2,
   parameter int CW      = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  sense_t s,
   output phase_e phase,
   output logic   gate_hi,
   output logic   gate_lo
);
   localparam logic [CW-1:0] FIX_LAST = CW'(FIX_CYC - 1);
   localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);
   localparam logic [CW-1:0] HSD_LAST = CW'(HSD_CYC - 1);

   phase_e        phase_q, phase_d;
   logic          seen_q;
   logic [CW-1:0] dwell;
   logic          adapt_go, fixed_go, limit_go;

   dtg_timer #(.CW(CW)) u_dwell (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(phase_d != phase_q),
      .count(dwell)
   );

   assign adapt_go = seen_q && s.sw_lo;
   assign fixed_go = !seen_q && !s.sw_hi && (dwell == FIX_LAST);
   assign limit_go = (dwell == TMO_LAST);

   always_comb begin
      phase_d = phase_q;
      if (!s.en) begin
         phase_d = PH_IDLE;
      end else begin
         unique case (phase_q)
            PH_IDLE:    phase_d = s.pwm ? PH_HI_WAIT : PH_LO_WAIT;
            PH_HI_WAIT: if (!s.pwm)            phase_d = PH_LO_WAIT;
                        else if (s.lg_off)     phase_d = PH_HI_HOLD;
            PH_HI_HOLD: if (!s.pwm)            phase_d = PH_LO_WAIT;
                        else if (dwell == HSD_LAST) phase_d = PH_HI_ON;
            PH_HI_ON:   if (!s.pwm)            phase_d = PH_LO_WAIT;
            PH_LO_WAIT: if (s.pwm)             phase_d = PH_HI_WAIT;
                        else if (adapt_go || fixed_go || limit_go)
                                               phase_d = PH_LO_ON;
            PH_LO_ON:   if (s.pwm)             phase_d = PH_HI_WAIT;
            default:                           phase_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         seen_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_LO_WAIT && phase_d == PH_LO_WAIT)
            seen_q <= seen_q | s.sw_hi;
         else
            seen_q <= 1'b0;
      end
   end

   assign phase   = phase_q;
   assign gate_hi = (phase_q == PH_HI_ON);
   assign gate_lo = (phase_q == PH_LO_ON);
endmodule

// File: rtl/deadtime_gate_ctrl.sv
`timescale 1ns/1ps
module deadtime_gate_ctrl
   import dtg_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 20000,
   parameter int LO_FIXED_PS   = 150000,
   parameter int LO_LIMIT_PS   = 190000,
   parameter int HI_GUARD_PS   = 30000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_in,
   input  logic shut_n,
   input  logic sw_below,
   input  logic sw_above,
   input  logic lsg_low,
   output logic gate_hi,
   output logic gate_lo
);
   localparam int FIX_CYC = int'(to_cycles(LO_FIXED_PS, CLK_PERIOD_PS));
   localparam int TMO_CYC = int'(to_cycles(LO_LIMIT_PS, CLK_PERIOD_PS));
   localparam int HSD_CYC = int'(to_cycles(HI_GUARD_PS, CLK_PERIOD_PS));
   localparam int CW      = $clog2(TMO_CYC + 1);
   localparam int SW      = $bits(sense_t);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FIX_CYC < 2) begin : g_bad_fix
      $error("fixed dead-time must span at least 2 cycles");
   end
   if (TMO_CYC <= FIX_CYC) begin : g_bad_tmo
      $error("limit delay must exceed the fixed delay");
   end
   if (HSD_CYC < 1) begin : g_bad_hsd
      $error("guard delay must be at least 1 cycle");
   end

   sense_t raw, synced;
   phase_e cur_phase;

   assign raw.pwm    = pwm_in;
   assign raw.en     = shut_n;
   assign raw.sw_lo  = sw_below;
   assign raw.sw_hi  = sw_above;
   assign raw.lg_off = lsg_low;

   dtg_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw),
      .q    (synced)
   );

   dtg_seq #(
      .FIX_CYC(FIX_CYC),
      .TMO_CYC(TMO_CYC),
      .HSD_CYC(HSD_CYC),
      .CW     (CW)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .s      (synced),
      .phase  (cur_phase),
      .gate_hi(gate_hi),
      .gate_lo(gate_lo)
   );
endmodule

// File: rtl/deadtime_gate_ctrl_chk.sv
`timescale 1ns/1ps
module deadtime_gate_ctrl_chk
   import dtg_pkg::*;
#(
   parameter int TMO_CYC     = 10,
   parameter int SYNC_STAGES = 2
) (
   input logic   clk,
   input logic   rst_n,
   input logic   shut_n,
   input logic   gate_hi,
   input logic   gate_lo,
   input phase_e phase
);
   localparam int LAT = SYNC_STAGES + 1;
   localparam int RW  = $clog2(TMO_CYC + 2);

   logic [LAT-1:0] off_hist;
   logic [RW-1:0]  wait_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_hist <= '0;
         wait_len <= '0;
      end else begin
         off_hist <= {off_hist[LAT-2:0], !shut_n};
         if (phase == PH_LO_WAIT) wait_len <= wait_len + 1'b1;
         else                     wait_len <= '0;
      end
   end

   // R2
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   // R3
   shutdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_hist[LAT-1] |-> (!gate_hi && !gate_lo));

   // R6
   hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> (!$past(gate_lo) && !$past(gate_lo, 2)));

   // R8
   lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo) |-> (!$past(gate_hi) && !$past(gate_hi, 2)));

   // R9
   limit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LO_WAIT) |-> (wait_len < RW'(TMO_CYC)));
endmodule

bind deadtime_gate_ctrl deadtime_gate_ctrl_chk #(
   .TMO_CYC    (TMO_CYC),
   .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .shut_n (shut_n),
   .gate_hi(gate_hi),
   .gate_lo(gate_lo),
   .phase  (cur_phase)
);

// File: tb/deadtime_gate_ctrl_test.sv
`timescale 1ns/1ps
module deadtime_gate_ctrl_test;
   localparam int FIX  = (150000 + 19999) / 20000;
   localparam int LIM  = (190000 + 19999) / 20000;
   localparam int HSD  = (30000 + 19999) / 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_in = 1'b0;
   logic shut_n = 1'b1;
   logic sw_below = 1'b1;
   logic sw_above = 1'b0;
   logic lsg_low = 1'b0;
   logic gate_hi, gate_lo;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   deadtime_gate_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .shut_n(shut_n),
      .sw_below(sw_below), .sw_above(sw_above), .lsg_low(lsg_low),
      .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_gates(input string tag, input logic eh, input logic el);
      checks++;
      if (gate_hi !== eh || gate_lo !== el) begin
         fails++;
         $display("FAIL %s: gate_hi=%b gate_lo=%b expected gate_hi=%b gate_lo=%b",
                  tag, gate_hi, gate_lo, eh, el);
      end
   endtask

   // bring the stage to high side on; node_high picks the sense flags
   task automatic go_high(input logic node_high);
      lsg_low = 1'b1; pwm_in = 1'b1;
      tick(12);
      sw_above = node_high; sw_below = !node_high;
      tick(4);
   endtask

   task automatic go_low;
      sw_above = 1'b0; sw_below = 1'b1; pwm_in = 1'b0;
      tick(14);
      lsg_low = 1'b0;
      tick(2);
   endtask

   task automatic t_reset;
      tick(3);
      expect_gates("R1 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      tick(1);
      expect_gates("R1 after release", 1'b0, 1'b0);
      tick(20);
      expect_gates("R4 low level selects low side", 1'b0, 1'b1);
   endtask

   task automatic t_rise;
      pwm_in = 1'b1;
      tick(2);  expect_gates("R5 before due", 1'b0, 1'b1);
      tick(1);  expect_gates("R5 low side released", 1'b0, 1'b0);
      tick(6);  expect_gates("R6 waits for gate decay", 1'b0, 1'b0);
      lsg_low = 1'b1;
      tick(2 + HSD); expect_gates("R6 guard not over", 1'b0, 0);
      tick(1);  expect_gates("R6 high side on", 1'b1, 1'b0);
      sw_above = 1'b1; sw_below = 1'b0;
      tick(10); expect_gates("R4 high level selects high side", 1'b1, 1'b0);
   endtask

   task automatic t_fall_adaptive;
      pwm_in = 1'b0;
      tick(2);  expect_gates("R7 before due", 1'b1, 1'b0);
      tick(1);  expect_gates("R7 high side released", 1'b0, 1'b0);
      tick(2);
      sw_above = 1'b0; sw_below = 1'b1;
      tick(2);  expect_gates("R7 node fall not yet seen", 1'b0, 1'b0);
      tick(1);  expect_gates("R7 adaptive turn-on", 1'b0, 1'b1);
      lsg_low = 1'b0;
      tick(2);
   endtask

   task automatic t_fall_fixed;
      go_high(1'b0);
      pwm_in = 1'b0;
      tick(3);       expect_gates("R8 high side released", 1'b0, 1'b0);
      tick(FIX - 1); expect_gates("R8 fixed delay not over", 1'b0, 1'b0);
      tick(1);       expect_gates("R8 fixed delay turn-on", 1'b0, 1'b1);
      lsg_low = 1'b0;
      tick(2);
   endtask

   task automatic t_fall_limit;
      go_high(1'b1);
      pwm_in = 1'b0;
      tick(2 + LIM); expect_gates("R9 limit not reached", 1'b0, 1'b0);
      tick(1);       expect_gates("R9 limit turn-on", 1'b0, 1'b1);
      sw_above = 1'b0; sw_below = 1'b1; lsg_low = 1'b0;
      tick(2);
   endtask

   task automatic t_cancel;
      go_low();
      pwm_in = 1'b1;
      tick(3);       expect_gates("R10 rise pending", 1'b0, 1'b0);
      pwm_in = 1'b0;
      tick(2 + FIX); expect_gates("R10 high never asserted", 1'b0, 1'b0);
      tick(1);       expect_gates("R10 low side after cancel", 1'b0, 1'b1);
      go_high(1'b0);
      pwm_in = 1'b0;
      tick(3);       expect_gates("R10 fall pending", 1'b0, 1'b0);
      pwm_in = 1'b1;
      tick(3 + HSD); expect_gates("R10 low never asserted", 1'b0, 1'b0);
      tick(1);       expect_gates("R10 high side after cancel", 1'b1, 1'b0);
   endtask

   task automatic t_shutdown;
      shut_n = 1'b0;
      tick(2);  expect_gates("R3 before due", 1'b1, 1'b0);
      tick(1);  expect_gates("R3 forced low", 1'b0, 1'b0);
      pwm_in = 1'b0;
      tick(15); expect_gates("R3 pwm low ignored", 1'b0, 1'b0);
      pwm_in = 1'b1;
      tick(15); expect_gates("R3 pwm high ignored", 1'b0, 1'b0);
      lsg_low = 1'b1;
      shut_n = 1'b1;
      tick(3 + HSD); expect_gates("R11 sequence after release", 1'b0, 1'b0);
      tick(1);       expect_gates("R11 high side after release", 1'b1, 1'b0);
   endtask

   initial begin
      t_reset();
      t_rise();
      t_fall_adaptive();
      t_fall_fixed();
      t_fall_limit();
      t_cancel();
      t_shutdown();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule